// File: doc/BRIEF.md
# Scalar Float Exponent Extraction Unit

This unit takes one single-precision floating-point operand and returns the integer part of the base-2 logarithm of its magnitude. The result is encoded as a single-precision float, so an input of 8.0 yields 3.0 and an input of 0.3 yields -2.0. Subnormal operands are normalized with a leading-zero count, so they give their true exponent rather than a fixed floor value. Zero, infinity and NaN operands are mapped to fixed special encodings.

The 32-bit result is placed in the low lane of a 128-bit destination word, and the upper 96 bits are copied from a separate pass-through operand. A write-mask controls the low lane. When the mask is off, the lane either keeps the value it last held or is cleared, depending on a zeroing/merging select. The unit raises two flags: invalid, for a signaling NaN, and denormal, for a subnormal operand. The design has a single register stage, so all outputs appear one clock edge after the inputs are presented.

Top module: `fexp_extract_unit`

## Requirements
- R1: The operand uses bit 31 as the sign, bits 30:23 as the exponent field with bias 127, and bits 22:0 as the fraction. Every output takes the value computed from the inputs present at a rising clock edge, and holds it until the next edge.
- R2: For a normal operand with exponent field e, the low lane is the exact single-precision value of e-127, whatever the operand's sign. The value 0 is encoded as 0x00000000, and negative values have bit 31 set.
- R3: For a subnormal operand (field e=0, fraction f nonzero), the low lane encodes -127 minus the number of leading zeros of f counted over 23 bits. This covers the range -149 to -127, and the denormal flag is raised.
- R4: A zero of either sign yields 0xFF800000, and an infinity of either sign yields 0x7F800000. A NaN yields the operand with fraction bit 22 forced to 1. A NaN whose bit 22 is 0 (signaling) raises the invalid flag.
- R5: The low lane takes the computed value when the mask enable is 0 or the mask bit is 1. With the mask enable at 1 and the mask bit at 0, the low lane becomes 0 when the zero select is 1, and keeps its previous value when the zero select is 0.
- R6: Result bits 127:32 always equal bits 127:32 of the pass-through operand, regardless of the mask state.
- R7: Only the invalid and denormal flags exist, and they are never raised together. Neither is raised for a normal, zero, infinite or quiet NaN operand.
- R8: When the low lane is masked off, neither flag is raised, whatever the operand.
- R9: While reset is held, the result word and both flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_pass_i | input | 128 | Pass-through operand supplying result bits 127:32 |
| src_op_i | input | 32 | Single-precision operand whose exponent is extracted |
| wmask_en_i | input | 1 | 1 = the write-mask applies to the low lane |
| wmask_bit_i | input | 1 | Mask bit for the low lane |
| zero_sel_i | input | 1 | Masked-off behaviour: 1 = clear the lane, 0 = keep the previous value |
| res_o | output | 128 | Registered result word |
| invalid_o | output | 1 | Registered invalid flag |
| denorm_o | output | 1 | Registered denormal flag |

## Verification
The bench builds the unit with its default parameters: an 8-bit exponent, a 23-bit fraction and a 128-bit destination. With these values every exponent code from 0 to 255 can be swept, and a subnormal can be placed at each of the 23 leading-one positions, so the full output range from -149 to 127 is checked against the bench's own integer-to-float model. Every combination of mask enable, mask bit and zero select is crossed with random operands. Merge mode is run back to back so that the held low lane is carried over from the previous result.

// File: rtl/fexp_pkg.sv
package fexp_pkg;
  // Operand class decoded from the exponent and fraction fields
  typedef enum logic [2:0] {
    CL_ZERO,
    CL_SUB,
    CL_NORM,
    CL_INF,
    CL_QNAN,
    CL_SNAN
  } fclass_e;
endpackage

// File: rtl/fexp_classify.sv
module fexp_classify
  import fexp_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  parameter int IW     = EXP_W + 2
) (
  input  logic [EXP_W-1:0]     exp_i,
  input  logic [FRAC_W-1:0]    frac_i,
  output fclass_e              cls_o,
  output logic signed [IW-1:0] int_exp_o
);
  localparam int BIAS = (1 << (EXP_W - 1)) - 1;

  // Leading zeros of the fraction, counted from its top bit
  function automatic int lead_zeros(input logic [FRAC_W-1:0] f);
    int   c;
    logic seen;
    c    = 0;
    seen = 1'b0;
    for (int i = FRAC_W - 1; i >= 0; i--) begin
      if (!seen && !f[i]) c++;
      else seen = 1'b1;
    end
    return c;
  endfunction

  int t;
  always_comb begin
    t     = 0;
    cls_o = CL_NORM;
    if (exp_i == '0) begin
      if (frac_i == '0) cls_o = CL_ZERO;
      else begin
        cls_o = CL_SUB;
        t     = -BIAS - lead_zeros(frac_i);
      end
    end else if (exp_i == '1) begin
      if (frac_i == '0)             cls_o = CL_INF;
      else if (frac_i[FRAC_W-1])    cls_o = CL_QNAN;
      else                          cls_o = CL_SNAN;
    end else begin
      t = int'(exp_i) - BIAS;
    end
  end

  assign int_exp_o = IW'(t);
endmodule

// File: rtl/fexp_int2fp.sv
module fexp_int2fp #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  parameter int IW     = EXP_W + 2   // must not exceed FRAC_W+1 for exactness
) (
  input  logic signed [IW-1:0]       n_i,
  output logic [EXP_W+FRAC_W:0]      fp_o
);
  localparam int BIAS = (1 << (EXP_W - 1)) - 1;

  // Exact conversion of a small signed integer to a float encoding
  function automatic logic [EXP_W+FRAC_W:0] to_float(input logic signed [IW-1:0] n);
    logic [IW-1:0]     mag;
    logic [FRAC_W:0]   sh;
    int                p;
    mag = n[IW-1] ? IW'(-n) : IW'(n);
    p   = 0;
    for (int i = 0; i < IW; i++) if (mag[i]) p = i;
    sh  = (FRAC_W + 1)'(mag) << (FRAC_W - p);
    if (mag == '0) return '0;
    return {n[IW-1], EXP_W'(BIAS + p), sh[FRAC_W-1:0]};
  endfunction

  assign fp_o = to_float(n_i);
endmodule

// File: rtl/fexp_wmerge.sv
module fexp_wmerge #(
  parameter int DST_W  = 128,
  parameter int LANE_W = 32
) (
  input  logic [DST_W-1:LANE_W] upper_i,
  input  logic [LANE_W-1:0]     lane_new_i,
  input  logic [LANE_W-1:0]     lane_old_i,
  input  logic                  en_i,
  input  logic                  bit_i,
  input  logic                  zsel_i,
  output logic                  take_o,
  output logic [DST_W-1:0]      word_o
);
  assign take_o = !en_i || bit_i;

  always_comb begin
    word_o[DST_W-1:LANE_W] = upper_i;
    if (take_o)      word_o[LANE_W-1:0] = lane_new_i;
    else if (zsel_i) word_o[LANE_W-1:0] = '0;
    else             word_o[LANE_W-1:0] = lane_old_i;
  end
endmodule

// File: rtl/fexp_extract_unit.sv
module fexp_extract_unit
  import fexp_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  parameter int DST_W  = 128
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [DST_W-1:0]            src_pass_i,
  input  logic [EXP_W+FRAC_W:0]       src_op_i,
  input  logic                        wmask_en_i,
  input  logic                        wmask_bit_i,
  input  logic                        zero_sel_i,
  output logic [DST_W-1:0]            res_o,
  output logic                        invalid_o,
  output logic                        denorm_o
);
  localparam int FW   = 1 + EXP_W + FRAC_W;
  localparam int IW   = EXP_W + 2;
  localparam int BIAS = (1 << (EXP_W - 1)) - 1;

  // Named internal events
  fclass_e              cls_w;
  logic signed [IW-1:0] int_exp_w;
  logic [FW-1:0]        int_fp_w;
  logic [FW-1:0]        conv_w;
  logic [DST_W-1:0]     word_w;
  logic                 take_w, inv_w, den_w;

  fexp_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .IW(IW)) u_cls (
    .exp_i     (src_op_i[FW-2:FRAC_W]),
    .frac_i    (src_op_i[FRAC_W-1:0]),
    .cls_o     (cls_w),
    .int_exp_o (int_exp_w)
  );

  fexp_int2fp #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .IW(IW)) u_cvt (
    .n_i  (int_exp_w),
    .fp_o (int_fp_w)
  );

  // Special operands override the converted exponent
  always_comb begin
    unique case (cls_w)
      CL_ZERO:         conv_w = {1'b1, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
      CL_INF:          conv_w = {1'b0, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
      CL_QNAN, CL_SNAN: conv_w = {src_op_i[FW-1], {EXP_W{1'b1}}, 1'b1, src_op_i[FRAC_W-2:0]};
      default:         conv_w = int_fp_w;
    endcase
  end

  assign inv_w = (cls_w == CL_SNAN);
  assign den_w = (cls_w == CL_SUB);

  fexp_wmerge #(.DST_W(DST_W), .LANE_W(FW)) u_mrg (
    .upper_i    (src_pass_i[DST_W-1:FW]),
    .lane_new_i (conv_w),
    .lane_old_i (res_o[FW-1:0]),
    .en_i       (wmask_en_i),
    .bit_i      (wmask_bit_i),
    .zsel_i     (zero_sel_i),
    .take_o     (take_w),
    .word_o     (word_w)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_o     <= '0;
      invalid_o <= 1'b0;
      denorm_o  <= 1'b0;
    end else begin
      res_o     <= word_w;
      invalid_o <= take_w && inv_w;
      denorm_o  <= take_w && den_w;
    end
  end

  // R2: a normal operand with unbiased exponent 0 converts to +0.0
  a_r2_zero_exp: assert property (@(posedge clk) disable iff (!rst_n)
    (cls_w == CL_NORM && int_exp_w == '0) |-> (int_fp_w == '0));

  // R3: subnormal exponents stay within the subnormal range
  a_r3_sub_range: assert property (@(posedge clk) disable iff (!rst_n)
    den_w |-> (int_exp_w <= IW'(-BIAS) && int_exp_w >= IW'(-(BIAS + FRAC_W - 1))));

  // R5: zeroing clears a masked-off lane
  a_r5_zeroing: assert property (@(posedge clk) disable iff (!rst_n)
    (wmask_en_i && !wmask_bit_i && zero_sel_i) |=> (res_o[FW-1:0] == '0));

  // R5: merging holds a masked-off lane
  a_r5_merge_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (wmask_en_i && !wmask_bit_i && !zero_sel_i) |=> $stable(res_o[FW-1:0]));

  // R6: upper bits follow the pass-through operand
  a_r6_upper_pass: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (res_o[DST_W-1:FW] == $past(src_pass_i[DST_W-1:FW])));

  // R7: the two flags are never raised together
  a_r7_flags_excl: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({invalid_o, denorm_o}));

  // R8: a masked-off lane raises no flag
  a_r8_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (wmask_en_i && !wmask_bit_i) |=> (!invalid_o && !denorm_o));
endmodule

// File: tb/sim_fexp_extract_unit.sv
module sim_fexp_extract_unit;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [127:0] src_pass = '0;
  logic [31:0]  src_op = '0;
  logic         m_en = 1'b0, m_bit = 1'b0, zsel = 1'b0;
  logic [127:0] res;
  logic         inv, den;

  int checks = 0, errors = 0;
  logic [31:0] exp_low = '0;
  bit done = 0;

  always #4 clk = ~clk;  // 125 MHz

  fexp_extract_unit u0 (
    .clk(clk), .rst_n(rst_n), .src_pass_i(src_pass), .src_op_i(src_op),
    .wmask_en_i(m_en), .wmask_bit_i(m_bit), .zero_sel_i(zsel),
    .res_o(res), .invalid_o(inv), .denorm_o(den)
  );

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  // Reference: floor(log2|x|) by locating the highest set bit
  function automatic int ref_int(input logic [31:0] x);
    int h;
    if (x[30:23] != 0) return int'(x[30:23]) - 127;
    h = 0;
    for (int i = 0; i < 23; i++) if (x[i]) h = i;
    return h - 149;
  endfunction

  function automatic logic [31:0] ref_float(input int k);
    int m, p;
    logic [31:0] fr;
    if (k == 0) return 32'h0;
    m = (k < 0) ? -k : k;
    p = 0;
    while ((m >> (p + 1)) != 0) p++;
    fr = 32'((m - (1 << p)) << (23 - p));
    return {k < 0, 8'(127 + p), fr[22:0]};
  endfunction

  function automatic logic [31:0] ref_low(input logic [31:0] x);
    if (x[30:23] == 8'hFF)
      return (x[22:0] == 0) ? 32'h7F80_0000 : {x[31], 8'hFF, 1'b1, x[21:0]};
    if (x[30:0] == 0) return 32'hFF80_0000;
    return ref_float(ref_int(x));
  endfunction

  task automatic apply(input logic [127:0] sp, input logic [31:0] op,
                       input logic en, input logic mb, input logic zs);
    logic take, snan, sub;
    string tl, tf;
    @(negedge clk);
    src_pass = sp; src_op = op; m_en = en; m_bit = mb; zsel = zs;
    @(posedge clk); #2;
    take = !en || mb;
    snan = (op[30:23] == 8'hFF) && (op[22:0] != 0) && !op[22];
    sub  = (op[30:23] == 0) && (op[22:0] != 0);
    if (take) exp_low = ref_low(op);
    else if (zs) exp_low = '0;
    if (!take) tl = "R5";
    else if (sub) tl = "R3";
    else if (op[30:23] == 0 || op[30:23] == 8'hFF) tl = "R4";
    else tl = "R2";
    if (!take) tf = "R8"; else if (sub) tf = "R3"; else if (snan) tf = "R4"; else tf = "R7";
    chk({tl, " low lane"}, {96'h0, res[31:0]}, {96'h0, exp_low});
    chk("R6 upper bits", {res[127:32], 32'h0}, {sp[127:32], 32'h0});
    chk({tf, " flags"}, {126'h0, inv, den}, {126'h0, take && snan, take && sub});
  endtask

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  initial begin
    void'($urandom(32'd4242));
    src_pass = {4{32'hDEAD_BEEF}}; src_op = 32'h4000_0000;
    repeat (3) @(posedge clk);
    #2;
    chk("R9 reset word", res, '0);
    chk("R9 reset flags", {126'h0, inv, den}, '0);
    @(negedge clk); rst_n = 1'b1;

    // R1: output changes only at the clock edge
    @(negedge clk);
    src_op = 32'h4100_0000; m_en = 0;   // 8.0 -> 3.0
    @(posedge clk); #2;
    chk("R1 registered", {96'h0, res[31:0]}, {96'h0, 32'h4040_0000});
    @(negedge clk); src_op = 32'h3F80_0000;  // 1.0 -> 0.0
    #1 chk("R1 held before edge", {96'h0, res[31:0]}, {96'h0, 32'h4040_0000});
    exp_low = 32'h4040_0000;

    apply(rnd128(), 32'h3F80_0000, 0, 0, 0);   // R2 +0.0
    chk("R2 one->zero", {96'h0, res[31:0]}, 128'h0);
    apply(rnd128(), 32'hBF00_0000, 0, 0, 0);   // -0.5 -> -1.0
    chk("R2 neg half", {96'h0, res[31:0]}, {96'h0, 32'hBF80_0000});
    apply(rnd128(), 32'h7F7F_FFFF, 0, 0, 0);   // 127
    chk("R2 max normal", {96'h0, res[31:0]}, {96'h0, 32'h42FE_0000});
    apply(rnd128(), 32'h0080_0000, 0, 0, 0);   // -126
    apply(rnd128(), 32'h0000_0000, 0, 0, 0);
    chk("R4 +zero", {96'h0, res[31:0]}, {96'h0, 32'hFF80_0000});
    apply(rnd128(), 32'h8000_0000, 0, 0, 0);
    apply(rnd128(), 32'hFF80_0000, 0, 0, 0);
    chk("R4 -inf", {96'h0, res[31:0]}, {96'h0, 32'h7F80_0000});
    apply(rnd128(), 32'h7FC1_2345, 0, 0, 0);   // quiet NaN
    apply(rnd128(), 32'hFF80_0001, 1, 1, 0);   // signaling NaN
    chk("R4 snan quieted", {96'h0, res[31:0]}, {96'h0, 32'hFFC0_0001});
    chk("R4 snan invalid", {127'h0, inv}, 128'h1);
    apply(rnd128(), 32'h0000_0001, 0, 0, 0);   // smallest subnormal
    chk("R3 min sub", {96'h0, res[31:0]}, {96'h0, 32'hC315_0000});
    for (int z = 0; z < 23; z++)
      apply(rnd128(), {9'h0, 23'(($urandom | 32'h40_0000) >> z)}, $urandom, 1, 0);

    // R5: all mask combinations, merge runs back to back
    for (int c = 0; c < 8; c++) begin
      apply(rnd128(), 32'h4200_0000, 0, 0, 0);
      apply(rnd128(), $urandom, c[2], c[1], c[0]);
      apply(rnd128(), 32'h0000_0010, c[2], c[1], c[0]);  // subnormal under mask
      apply(rnd128(), 32'h7F80_0001, c[2], c[1], c[0]);  // snan under mask
    end

    // Sweep every exponent code with random fraction, sign and mask
    for (int e = 0; e < 256; e++)
      apply(rnd128(), {1'($urandom), 8'(e), 23'($urandom)},
            $urandom, $urandom, $urandom);

    for (int i = 0; i < 1500; i++)
      apply(rnd128(), $urandom, $urandom, $urandom, $urandom);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule